// File: doc/BRIEF.md
# Two-Phase Wait Timeout Unit

A thread that must wait does not leave the processor at once. First its hardware context is disabled but stays loaded, for a bounded phase. If nobody wakes the thread within that phase, the thread is unloaded. This unit runs that policy for every hardware context. Each context has its own countdown timer. The timer is armed when the context is switched out to wait. The phase length is given with the start pulse, or a length of zero selects the default of ALPHA x BLOCK_COST cycles. BLOCK_COST stands for the cycles needed to save and later restore one context, and it defaults to 1000.

When a timer runs out before any wake-up, the unit issues an unload request for that context. Only one request leaves the unit per cycle, and several due contexts are served in ascending context number. The wake-up path pulses the context's wake input. The unit answers with one of two pulses. A re-enable pulse means the thread is still resident and only needs its context switched back on. A reload pulse means the thread has already been unloaded and has to take the full restore path. Saving and restoring register state, and keeping the wait queues, are done by other logic.

Top module: `twophase_wait_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, every bit of `resident_o`, `unloaded_o`, `reenable_o`, `reload_o` and `unload_valid_o` is 0.
- R2: A start pulse for context i that is sampled at a clock edge sets `resident_o[i]` after that edge. The phase length L is `phase_len_i`, or ALPHA*BLOCK_COST (1000 by default) when `phase_len_i` is 0.
- R3: If no wake-up and no new start reach context i, then `unload_valid_o` is 1 with `unload_ctx_o` = i (the context number in binary) in the cycle that begins L+1 edges after the start edge. In that same cycle `resident_o[i]` drops and `unloaded_o[i]` rises.
- R4: A wake-up for a resident context produces a one-cycle `reenable_o[i]` pulse after the sampling edge and returns the context to idle. No unload request for i follows.
- R5: A wake-up sampled at the edge where the count runs out, or at any later edge before the unload request is issued, counts as arriving in time. It gives a re-enable and no unload.
- R6: A wake-up for an unloaded context produces a one-cycle `reload_o[i]` pulse after the sampling edge and returns the context to idle. `reenable_o[i]` and `reload_o[i]` are never high together.
- R7: A wake-up for an idle context has no effect. No pulse appears and the status bits stay 0.
- R8: When several contexts become due in the same cycle, their unload requests come out on consecutive cycles, lowest context number first.
- R9: A start pulse in any state (waiting, due, or unloaded) reloads the full count and makes the context resident again.
- R10: Contexts are independent. Starting, waking or expiring one context does not change the timing or status of another.
- R11: When a start and a wake-up reach the same context at the same edge, the start wins. No re-enable or reload pulse is produced, and a new phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | NUM_CTX | Per-context pulse: context switched out to wait, arm its timer |
| phase_len_i | input | CNT_W | Phase length for the contexts started this cycle; 0 selects the default |
| wake_i | input | NUM_CTX | Per-context wake-up pulse |
| unload_valid_o | output | 1 | An unload request is presented this cycle |
| unload_ctx_o | output | IDX_W | Binary number of the context to unload |
| resident_o | output | NUM_CTX | Context is waiting and still loaded |
| unloaded_o | output | NUM_CTX | Context's thread has been unloaded and still waits |
| reenable_o | output | NUM_CTX | One-cycle answer to a wake-up: only re-enable the context |
| reload_o | output | NUM_CTX | One-cycle answer to a wake-up: take the reload path |

## Verification
The start edge is the edge that samples a start pulse. Status bits change right after that edge. An unload request becomes visible L+1 cycles after it: one edge to go from counting to due, and one edge through the registered arbiter. A re-enable or reload pulse is visible in the cycle right after the edge that samples the wake-up. The bench counts cycles and, from these rules, computes the exact cycle in which each pulse is due. It places that cycle in a scoreboard queue. At every falling edge a monitor compares what is expected for the current cycle with the outputs, so a pulse that is early, late, missing or unexpected is reported. Wake-ups are aimed at the expiry edge and at the due-but-not-yet-granted edge to exercise the in-time rule.

// File: rtl/wtp_pkg.sv
package wtp_pkg;

    // Per-context waiting state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no thread waiting
        ST_WAIT = 2'd1,   // disabled but loaded, counting down
        ST_DUE  = 2'd2,   // phase over, unload request not yet issued
        ST_OUT  = 2'd3    // unloaded, waiting for wake-up
    } ctx_st_e;

endpackage

// File: rtl/wtp_ctx_timer.sv
module wtp_ctx_timer
    import wtp_pkg::*;
#(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] DEF_LEN = 16'd1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             wake_i,
    input  logic             grant_i,
    output logic             due_o,
    output logic             resident_o,
    output logic             unloaded_o,
    output logic             reenable_o,
    output logic             reload_o
);

    typedef struct packed {
        ctx_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             reen;
        logic             rel;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.reen = 1'b0;
        tmr_d.rel  = 1'b0;
        if (start_i) begin
            tmr_d.st  = ST_WAIT;
            tmr_d.cnt = (len_i == '0) ? DEF_LEN : len_i;
        end else if (wake_i) begin
            unique case (tmr_q.st)
                ST_WAIT, ST_DUE: begin
                    tmr_d.reen = 1'b1;
                    tmr_d.st   = ST_IDLE;
                end
                ST_OUT: begin
                    tmr_d.rel = 1'b1;
                    tmr_d.st  = ST_IDLE;
                end
                default: ;
            endcase
        end else begin
            unique case (tmr_q.st)
                ST_WAIT: begin
                    if (tmr_q.cnt <= CNT_W'(1)) tmr_d.st  = ST_DUE;
                    else                        tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
                end
                ST_DUE: if (grant_i) tmr_d.st = ST_OUT;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.st   <= ST_IDLE;
            tmr_q.cnt  <= '0;
            tmr_q.reen <= 1'b0;
            tmr_q.rel  <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign due_o      = (tmr_q.st == ST_DUE);
    assign resident_o = (tmr_q.st == ST_WAIT) || (tmr_q.st == ST_DUE);
    assign unloaded_o = (tmr_q.st == ST_OUT);
    assign reenable_o = tmr_q.reen;
    assign reload_o   = tmr_q.rel;

endmodule

// File: rtl/wtp_unload_arb.sv
module wtp_unload_arb #(
    parameter int NUM_CTX = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] cand_i,
    output logic [NUM_CTX-1:0] grant_o,
    output logic               valid_o,
    output logic [IDX_W-1:0]   ctx_o
);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] ctx;
    } arb_t;

    arb_t arb_d, arb_q;

    // lowest context number wins
    always_comb begin
        grant_o   = '0;
        arb_d     = '0;
        for (int i = NUM_CTX - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                grant_o   = '0;
                grant_o[i] = 1'b1;
                arb_d.valid = 1'b1;
                arb_d.ctx   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign valid_o = arb_q.valid;
    assign ctx_o   = arb_q.ctx;

endmodule

// File: rtl/twophase_wait_ctl.sv
module twophase_wait_ctl #(
    parameter int NUM_CTX    = 4,
    parameter int CNT_W      = 16,
    parameter int BLOCK_COST = 1000,
    parameter int ALPHA      = 1,
    localparam int IDX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] start_i,
    input  logic [CNT_W-1:0]   phase_len_i,
    input  logic [NUM_CTX-1:0] wake_i,
    output logic               unload_valid_o,
    output logic [IDX_W-1:0]   unload_ctx_o,
    output logic [NUM_CTX-1:0] resident_o,
    output logic [NUM_CTX-1:0] unloaded_o,
    output logic [NUM_CTX-1:0] reenable_o,
    output logic [NUM_CTX-1:0] reload_o
);

    localparam logic [CNT_W-1:0] DEF_LEN = CNT_W'(ALPHA * BLOCK_COST);

    logic [NUM_CTX-1:0] due;
    logic [NUM_CTX-1:0] grant;
    logic [NUM_CTX-1:0] cand;

    // a context touched by start or wake this edge is not offered for unload
    assign cand = due & ~wake_i & ~start_i;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        wtp_ctx_timer #(
            .CNT_W  (CNT_W),
            .DEF_LEN(DEF_LEN)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_i[g]),
            .len_i     (phase_len_i),
            .wake_i    (wake_i[g]),
            .grant_i   (grant[g]),
            .due_o     (due[g]),
            .resident_o(resident_o[g]),
            .unloaded_o(unloaded_o[g]),
            .reenable_o(reenable_o[g]),
            .reload_o  (reload_o[g])
        );
    end

    wtp_unload_arb #(
        .NUM_CTX(NUM_CTX),
        .IDX_W  (IDX_W)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (cand),
        .grant_o(grant),
        .valid_o(unload_valid_o),
        .ctx_o  (unload_ctx_o)
    );

endmodule

// File: rtl/wtp_checker.sv
module wtp_checker #(
    parameter int NUM_CTX = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CTX-1:0] start_i,
    input logic [NUM_CTX-1:0] wake_i,
    input logic               unload_valid_o,
    input logic [IDX_W-1:0]   unload_ctx_o,
    input logic [NUM_CTX-1:0] resident_o,
    input logic [NUM_CTX-1:0] unloaded_o,
    input logic [NUM_CTX-1:0] reenable_o,
    input logic [NUM_CTX-1:0] reload_o
);

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (resident_o & unloaded_o) == '0); // R3

    AST_UNLOAD_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n) unload_valid_o |-> unloaded_o[unload_ctx_o]); // R3

    AST_START_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n) (|start_i) |=> ((resident_o & $past(start_i)) == $past(start_i))); // R2

    AST_REEN_FROM_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n) (|reenable_o) |-> ((reenable_o & ~$past(resident_o)) == '0)); // R4

    AST_WAKE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n) (|(wake_i & resident_o & ~start_i)) |=> ((reenable_o & $past(wake_i & resident_o & ~start_i)) == $past(wake_i & resident_o & ~start_i))); // R4

    AST_RELOAD_FROM_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n) (|reload_o) |-> ((reload_o & ~$past(unloaded_o)) == '0)); // R6

    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (reenable_o & reload_o) == '0); // R6

endmodule

bind twophase_wait_ctl wtp_checker #(
    .NUM_CTX(NUM_CTX),
    .IDX_W  (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .wake_i        (wake_i),
    .unload_valid_o(unload_valid_o),
    .unload_ctx_o  (unload_ctx_o),
    .resident_o    (resident_o),
    .unloaded_o    (unloaded_o),
    .reenable_o    (reenable_o),
    .reload_o      (reload_o)
);

// File: tb/tb_twophase_wait_ctl.sv
module tb_twophase_wait_ctl;

    localparam int N    = 4;
    localparam int CW   = 16;
    localparam int IW   = 2;
    localparam int KUNL = 0;
    localparam int KREE = 1;
    localparam int KREL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  start_i = '0;
    logic [CW-1:0] phase_len_i = '0;
    logic [N-1:0]  wake_i = '0;
    logic          unload_valid_o;
    logic [IW-1:0] unload_ctx_o;
    logic [N-1:0]  resident_o, unloaded_o, reenable_o, reload_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    cyc;
        int    kind;
        int    ctx;
        string tag;
    } ev_t;
    ev_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    twophase_wait_ctl #(.NUM_CTX(N), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_len_i(phase_len_i),
        .wake_i(wake_i), .unload_valid_o(unload_valid_o), .unload_ctx_o(unload_ctx_o),
        .resident_o(resident_o), .unloaded_o(unloaded_o),
        .reenable_o(reenable_o), .reload_o(reload_o)
    );

    task automatic expect_ev(input int c, input int k, input int x, input string tag);
        ev_t e;
        e.cyc = c; e.kind = k; e.ctx = x; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic goto(input int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    // drive one-cycle pulse at the falling edge of cycle c
    task automatic pulse_at(input int c, input logic [N-1:0] st, input int ln, input logic [N-1:0] wk);
        goto(c);
        if (cyc != c) begin
            errors++;
            $display("FAIL bench timing: pulse at cycle %0d, expected %0d", cyc, c);
        end
        start_i = st; phase_len_i = CW'(ln); wake_i = wk;
        @(posedge clk);
        #1;
        start_i = '0; phase_len_i = '0; wake_i = '0;
    endtask

    task automatic status_at(input int c, input string tag, input logic [N-1:0] er, input logic [N-1:0] eu);
        goto(c);
        checks++;
        if (resident_o !== er || unloaded_o !== eu) begin
            errors++;
            $display("FAIL %s cyc %0d: resident %b unloaded %b, expected resident %b unloaded %b",
                     tag, cyc, resident_o, unloaded_o, er, eu);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        bit           e_uv;
        int           e_uc;
        logic [N-1:0] e_re, e_rl;
        string        tg;
        if (mon_on) begin
            e_uv = 1'b0; e_uc = 0; e_re = '0; e_rl = '0; tg = "R7";
            for (int i = exp_q.size() - 1; i >= 0; i--) begin
                if (exp_q[i].cyc == cyc) begin
                    if (exp_q[i].kind == KUNL) begin e_uv = 1'b1; e_uc = exp_q[i].ctx; end
                    else if (exp_q[i].kind == KREE) e_re[exp_q[i].ctx] = 1'b1;
                    else e_rl[exp_q[i].ctx] = 1'b1;
                    tg = exp_q[i].tag;
                    exp_q.delete(i);
                end
            end
            if (e_uv || unload_valid_o !== 1'b0 || e_re != '0 || reenable_o !== '0 ||
                e_rl != '0 || reload_o !== '0) begin
                checks++;
                if (unload_valid_o !== e_uv || (e_uv && int'(unload_ctx_o) != e_uc) ||
                    reenable_o !== e_re || reload_o !== e_rl) begin
                    errors++;
                    $display("FAIL %s cyc %0d: unload %b/%0d reen %b rel %b, expected unload %b/%0d reen %b rel %b",
                             tg, cyc, unload_valid_o, unload_ctx_o, reenable_o, reload_o,
                             e_uv, e_uc, e_re, e_rl);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        checks++;   // R1 during reset
        if ({resident_o, unloaded_o, reenable_o, reload_o, unload_valid_o} !== '0) begin
            errors++;
            $display("FAIL R1 in reset: outputs %b, expected 0",
                     {resident_o, unloaded_o, reenable_o, reload_o, unload_valid_o});
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        t = cyc + 1;
        status_at(t, "R1", 4'b0000, 4'b0000);

        // R2, R3, R6: expire then reload
        t = cyc + 2;
        pulse_at(t, 4'b0001, 6, 4'b0000);
        expect_ev(t + 8, KUNL, 0, "R3");
        status_at(t + 1, "R2", 4'b0001, 4'b0000);
        status_at(t + 9, "R3", 4'b0000, 4'b0001);
        pulse_at(t + 10, 4'b0000, 0, 4'b0001);
        expect_ev(t + 11, KREL, 0, "R6");
        status_at(t + 12, "R6", 4'b0000, 4'b0000);

        // R5: wake at the expiry edge
        t = cyc + 2;
        pulse_at(t, 4'b0010, 6, 4'b0000);
        pulse_at(t + 6, 4'b0000, 0, 4'b0010);
        expect_ev(t + 7, KREE, 1, "R5");
        status_at(t + 9, "R5", 4'b0000, 4'b0000);

        // R5: wake while due but not yet granted
        t = cyc + 2;
        pulse_at(t, 4'b1000, 6, 4'b0000);
        pulse_at(t + 7, 4'b0000, 0, 4'b1000);
        expect_ev(t + 8, KREE, 3, "R5");
        status_at(t + 10, "R5", 4'b0000, 4'b0000);

        // R4: early wake
        t = cyc + 2;
        pulse_at(t, 4'b0100, 10, 4'b0000);
        pulse_at(t + 3, 4'b0000, 0, 4'b0100);
        expect_ev(t + 4, KREE, 2, "R4");
        status_at(t + 14, "R4", 4'b0000, 4'b0000);

        // R7: wake on idle context
        t = cyc + 2;
        pulse_at(t, 4'b0000, 0, 4'b0100);
        status_at(t + 3, "R7", 4'b0000, 4'b0000);

        // R8: simultaneous expiry served lowest first
        t = cyc + 2;
        pulse_at(t, 4'b0111, 5, 4'b0000);
        expect_ev(t + 7, KUNL, 0, "R8");
        expect_ev(t + 8, KUNL, 1, "R8");
        expect_ev(t + 9, KUNL, 2, "R8");
        status_at(t + 10, "R8", 4'b0000, 4'b0111);
        pulse_at(t + 11, 4'b0000, 0, 4'b0111);
        expect_ev(t + 12, KREL, 0, "R6");
        expect_ev(t + 12, KREL, 1, "R6");
        expect_ev(t + 12, KREL, 2, "R6");

        // R9: restart while counting and while unloaded
        t = cyc + 4;
        pulse_at(t, 4'b0001, 8, 4'b0000);
        pulse_at(t + 4, 4'b0001, 8, 4'b0000);
        expect_ev(t + 14, KUNL, 0, "R9");
        status_at(t + 15, "R9", 4'b0000, 4'b0001);
        pulse_at(t + 16, 4'b0001, 3, 4'b0000);
        status_at(t + 17, "R9", 4'b0001, 4'b0000);
        expect_ev(t + 21, KUNL, 0, "R9");
        pulse_at(t + 22, 4'b0000, 0, 4'b0001);
        expect_ev(t + 23, KREL, 0, "R9");

        // R11: start and wake together
        t = cyc + 2;
        pulse_at(t, 4'b0010, 20, 4'b0000);
        pulse_at(t + 2, 4'b0010, 4, 4'b0010);
        expect_ev(t + 8, KUNL, 1, "R11");
        pulse_at(t + 9, 4'b0000, 0, 4'b0010);
        expect_ev(t + 10, KREL, 1, "R11");

        // R10: independent contexts
        t = cyc + 2;
        pulse_at(t, 4'b0001, 12, 4'b0000);
        pulse_at(t + 1, 4'b0100, 4, 4'b0000);
        pulse_at(t + 5, 4'b0000, 0, 4'b0001);
        expect_ev(t + 6, KREE, 0, "R10");
        expect_ev(t + 7, KUNL, 2, "R10");
        status_at(t + 8, "R10", 4'b0000, 4'b0100);
        pulse_at(t + 9, 4'b0000, 0, 4'b0100);
        expect_ev(t + 10, KREL, 2, "R10");

        // R2: zero length selects the default 1000
        t = cyc + 2;
        pulse_at(t, 4'b1000, 0, 4'b0000);
        expect_ev(t + 1002, KUNL, 3, "R2");
        status_at(t + 500, "R2", 4'b1000, 4'b0000);
        status_at(t + 1001, "R2", 4'b1000, 4'b0000);
        pulse_at(t + 1003, 4'b0000, 0, 4'b1000);
        expect_ev(t + 1004, KREL, 3, "R2");
        status_at(t + 1008, "R2", 4'b0000, 4'b0000);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3 scoreboard: %0d expected events never seen, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule